// File: doc/BRIEF.md
# Mode-Configurable Output Macrocell

This block is one output slice of a small sum-of-products programmable logic device. A product-term array outside the block supplies seven grouped term results and one spare term. The block ORs these into a sum and applies a chosen output polarity. It decides whether the result reaches the pin directly or through a D flip-flop. It picks the tri-state enable source and the feedback signal returned to the array.

Two device-wide mode bits select one of three device modes, and two per-slice bits set polarity and select register or combinational use. Together they decide three things: whether the spare term joins the sum, drives the output enable, or goes unused; whether the enable is fixed, comes from a term, or comes from the active-low enable pin; and whether feedback comes from the flip-flop or from the pad. The flip-flop is cleared by a power-on clear input and updates on the rising clock edge. Polarity is applied after the flip-flop, so it always stores the true sum.

Top module: `pmc_macrocell`

## Requirements
- R1: Mode bits `{mode_i[1], mode_i[0]}` decode as 2'b10 Simple, 2'b11 Complex, 2'b01 Registered. The reserved code 2'b00 gives `oe_o`=0, `fb_o`=`pad_i`, and a combinational pin value from all eight terms.
- R2: `pol_i`=1 makes `pin_o` equal the true sum (or flip-flop value), and `pol_i`=0 makes it the complement. Feedback is always true polarity.
- R3: In Simple mode with `regsel_i`=0, `pin_o` is the OR of all seven terms and the spare term, `oe_o`=1, and `fb_o`=`pad_i`.
- R4: In Simple mode with `regsel_i`=1, `oe_o`=0 and `fb_o`=`pad_i`, whatever the terms are.
- R5: In Complex mode the sum uses only the seven grouped terms, `oe_o` equals the spare term, `fb_o`=`pad_i`, and `regsel_i` has no effect.
- R6: In Registered mode with `regsel_i`=0, the OR of all eight terms is captured on the rising clock edge. `pin_o` shows the stored value (after polarity) from that edge on, `oe_o` = NOT `oe_pin_n_i`, and `fb_o` is the stored value.
- R7: In Registered mode with `regsel_i`=1, the output is combinational from the seven grouped terms, `oe_o` equals the spare term (the enable pin is ignored), and `fb_o`=`pad_i`.
- R8: While `por_i` is high the flip-flop is clear, without waiting for a clock edge. In the registered configuration `pin_o` is then 0 for `pol_i`=1 and 1 for `pol_i`=0, and `fb_o` is 0.
- R9: Outside the Registered/`regsel_i`=0 configuration the flip-flop keeps its value across clock edges. It is visible again on return to that configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Device clock pin, rising edge |
| por_i | input | 1 | Power-on clear, active high, asynchronous |
| mode_i | input | 2 | Device-wide mode bits {first, second} |
| pol_i | input | 1 | Polarity: 1 active high, 0 active low |
| regsel_i | input | 1 | Register/combinational and feedback select |
| terms_i | input | NUM_TERMS | Grouped product-term results |
| spare_term_i | input | 1 | Eighth (spare) product term |
| oe_pin_n_i | input | 1 | Active-low output-enable pin |
| pad_i | input | 1 | Value present at the I/O pad |
| pin_o | output | 1 | Value driven toward the pad |
| oe_o | output | 1 | Tri-state enable for the pad driver |
| fb_o | output | 1 | Feedback returned to the term array |

## Verification
The assertions assume that the mode and slice bits, terms, enable pin and pad value change only away from the rising clock edge. They also assume that the power-on clear is released between edges. The stimulus drives every input shortly after the falling edge, and it raises or drops the clear at mid-cycle points, so each sampled value is settled. The capture and hold checks ignore the first edge after the clear is released, because the flip-flop was held clear during the previous cycle.

// File: rtl/pmc_pkg.sv
`timescale 1ns/1ps
package pmc_pkg;

  // Device mode, encoded as {first global bit, second global bit}
  typedef enum logic [1:0] {
    PM_RSVD   = 2'b00,
    PM_REGD   = 2'b01,
    PM_SIMPLE = 2'b10,
    PM_CPLX   = 2'b11
  } pm_mode_e;

  typedef enum logic [1:0] {
    OE_ALWAYS,
    OE_NEVER,
    OE_TERM,
    OE_PIN
  } pm_oe_e;

  typedef struct packed {
    logic   spare_in_sum;
    logic   use_reg;
    logic   fb_from_reg;
    pm_oe_e oe_src;
  } pm_cfg_t;

  // Configuration decode table
  function automatic pm_cfg_t pm_decode(pm_mode_e m, logic rc);
    pm_cfg_t c;
    c.spare_in_sum = 1'b1;
    c.use_reg      = 1'b0;
    c.fb_from_reg  = 1'b0;
    c.oe_src       = OE_NEVER;
    case (m)
      PM_SIMPLE: c.oe_src = rc ? OE_NEVER : OE_ALWAYS;
      PM_CPLX: begin
        c.spare_in_sum = 1'b0;
        c.oe_src       = OE_TERM;
      end
      PM_REGD: begin
        if (rc) begin
          c.spare_in_sum = 1'b0;
          c.oe_src       = OE_TERM;
        end else begin
          c.use_reg     = 1'b1;
          c.fb_from_reg = 1'b1;
          c.oe_src      = OE_PIN;
        end
      end
      default: c.oe_src = OE_NEVER;
    endcase
    return c;
  endfunction

  function automatic logic pm_polar(logic v, logic pol);
    return pol ? v : ~v;
  endfunction

endpackage

// File: rtl/pmc_cfg_decode.sv
`timescale 1ns/1ps
module pmc_cfg_decode
  import pmc_pkg::*;
(
  input  logic [1:0] mode_i,
  input  logic       regsel_i,
  output pm_mode_e   mode_o,
  output pm_cfg_t    cfg_o
);

  assign mode_o = pm_mode_e'(mode_i);
  assign cfg_o  = pm_decode(mode_o, regsel_i);

  // The register and pin-sourced enable only ever come together
  always_comb begin
    a_r6_cfg_pair: assert (cfg_o.use_reg == (cfg_o.oe_src == OE_PIN));
  end

endmodule

// File: rtl/pmc_term_sum.sv
`timescale 1ns/1ps
module pmc_term_sum #(
  parameter int NUM_TERMS = 7
) (
  input  logic [NUM_TERMS-1:0] terms_i,
  input  logic                 spare_i,
  input  logic                 spare_en_i,
  output logic                 sum_narrow_o,
  output logic                 sum_wide_o,
  output logic                 sum_sel_o
);

  logic [NUM_TERMS:0] chain;

  assign chain[0] = 1'b0;
  for (genvar g = 0; g < NUM_TERMS; g++) begin : g_or
    assign chain[g+1] = chain[g] | terms_i[g];
  end

  assign sum_narrow_o = chain[NUM_TERMS];
  assign sum_wide_o   = sum_narrow_o | spare_i;
  assign sum_sel_o    = spare_en_i ? sum_wide_o : sum_narrow_o;

endmodule

// File: rtl/pmc_dreg.sv
`timescale 1ns/1ps
module pmc_dreg (
  input  logic clk_i,
  input  logic por_i,
  input  logic load_i,
  input  logic d_i,
  output logic q_o
);

  always_ff @(posedge clk_i or posedge por_i) begin
    if (por_i)       q_o <= 1'b0;
    else if (load_i) q_o <= d_i;
  end

  a_r6_capture: assert property (@(posedge clk_i) disable iff (por_i)
    (!$past(por_i) && $past(load_i)) |-> (q_o == $past(d_i)));

  a_r9_hold: assert property (@(posedge clk_i) disable iff (por_i)
    (!$past(por_i) && !$past(load_i)) |-> $stable(q_o));

endmodule

// File: rtl/pmc_macrocell.sv
`timescale 1ns/1ps
module pmc_macrocell
  import pmc_pkg::*;
#(
  parameter int NUM_TERMS = 7
) (
  input  logic                 clk_i,
  input  logic                 por_i,
  input  logic [1:0]           mode_i,
  input  logic                 pol_i,
  input  logic                 regsel_i,
  input  logic [NUM_TERMS-1:0] terms_i,
  input  logic                 spare_term_i,
  input  logic                 oe_pin_n_i,
  input  logic                 pad_i,
  output logic                 pin_o,
  output logic                 oe_o,
  output logic                 fb_o
);

  pm_mode_e mode;
  pm_cfg_t  cfg;
  logic     sum_narrow, sum_wide, comb_sum;
  logic     reg_q, pin_src;

  pmc_cfg_decode u_dec (
    .mode_i   (mode_i),
    .regsel_i (regsel_i),
    .mode_o   (mode),
    .cfg_o    (cfg)
  );

  pmc_term_sum #(.NUM_TERMS(NUM_TERMS)) u_sum (
    .terms_i      (terms_i),
    .spare_i      (spare_term_i),
    .spare_en_i   (cfg.spare_in_sum),
    .sum_narrow_o (sum_narrow),
    .sum_wide_o   (sum_wide),
    .sum_sel_o    (comb_sum)
  );

  pmc_dreg u_reg (
    .clk_i  (clk_i),
    .por_i  (por_i),
    .load_i (cfg.use_reg),
    .d_i    (sum_wide),
    .q_o    (reg_q)
  );

  assign pin_src = cfg.use_reg ? reg_q : comb_sum;
  assign pin_o   = pm_polar(pin_src, pol_i);
  assign fb_o    = cfg.fb_from_reg ? reg_q : pad_i;

  always_comb begin
    case (cfg.oe_src)
      OE_ALWAYS: oe_o = 1'b1;
      OE_TERM:   oe_o = spare_term_i;
      OE_PIN:    oe_o = ~oe_pin_n_i;
      default:   oe_o = 1'b0;
    endcase
  end

  // R1: reserved code keeps the driver off
  a_r1_rsvd_off: assert property (@(posedge clk_i) disable iff (por_i)
    (mode == PM_RSVD) |-> (!oe_o && fb_o == pad_i));

  // R3: simple output is always driven, feedback from pad
  a_r3_simple_drive: assert property (@(posedge clk_i) disable iff (por_i)
    (mode == PM_SIMPLE && !regsel_i) |-> (oe_o && fb_o == pad_i));

  // R4: simple input-only slice
  a_r4_simple_input: assert property (@(posedge clk_i) disable iff (por_i)
    (mode == PM_SIMPLE && regsel_i) |-> (!oe_o && fb_o == pad_i));

  // R5: complex enable follows the spare term
  a_r5_cplx_oe: assert property (@(posedge clk_i) disable iff (por_i)
    (mode == PM_CPLX) |-> (oe_o == spare_term_i && fb_o == pad_i));

  // R6: registered enable follows the active-low pin
  a_r6_oe_pin: assert property (@(posedge clk_i) disable iff (por_i)
    (mode == PM_REGD && !regsel_i) |-> (oe_o == !oe_pin_n_i));

  // R2: pin and true-polarity feedback agree exactly when active high
  a_r2_reg_pol: assert property (@(posedge clk_i) disable iff (por_i)
    (mode == PM_REGD && !regsel_i) |-> ((pin_o == fb_o) == pol_i));

  // R7: combinational slice in registered mode ignores the enable pin
  a_r7_regd_comb: assert property (@(posedge clk_i) disable iff (por_i)
    (mode == PM_REGD && regsel_i) |-> (oe_o == spare_term_i && fb_o == pad_i));

endmodule

// File: tb/pmc_macrocell_tb_top.sv
`timescale 1ns/1ps
module pmc_macrocell_tb_top;

  logic       clk = 1'b0;
  logic       por;
  logic [1:0] mode;
  logic       pol, regsel, spare, oen, pad;
  logic [6:0] terms;
  logic       pin, oe, fb;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  pmc_macrocell #(.NUM_TERMS(7)) dut_i (
    .clk_i        (clk),
    .por_i        (por),
    .mode_i       (mode),
    .pol_i        (pol),
    .regsel_i     (regsel),
    .terms_i      (terms),
    .spare_term_i (spare),
    .oe_pin_n_i   (oen),
    .pad_i        (pad),
    .pin_o        (pin),
    .oe_o         (oe),
    .fb_o         (fb)
  );

  task automatic check(input string req, input string what, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  // Row: {mode, pol, regsel, terms, spare, oen, pad, exp_pin, exp_oe, exp_fb}
  localparam int NV = 13;
  localparam logic [16:0] VEC [NV] = '{
    {2'b10, 1'b1, 1'b0, 7'b0000000, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0}, // R3 spare in sum
    {2'b10, 1'b1, 1'b0, 7'b0000000, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1}, // R3 zero sum
    {2'b10, 1'b0, 1'b0, 7'b0000100, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0}, // R2 active low
    {2'b10, 1'b0, 1'b0, 7'b0000000, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1}, // R2 active low
    {2'b10, 1'b1, 1'b1, 7'b1111111, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}, // R4
    {2'b10, 1'b1, 1'b1, 7'b0000000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1}, // R4
    {2'b11, 1'b1, 1'b1, 7'b0000000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0}, // R5 spare not summed
    {2'b11, 1'b1, 1'b1, 7'b1000000, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1}, // R5
    {2'b11, 1'b0, 1'b0, 7'b0000001, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1}, // R5 regsel ignored
    {2'b01, 1'b1, 1'b1, 7'b0000000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0}, // R7 pin oe ignored
    {2'b01, 1'b0, 1'b1, 7'b0010000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1}, // R7
    {2'b00, 1'b1, 1'b0, 7'b0000000, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1}, // R1 reserved
    {2'b00, 1'b0, 1'b0, 7'b0000000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}  // R1 reserved
  };
  localparam int VREQ [NV] = '{3, 3, 2, 2, 4, 4, 5, 5, 5, 7, 7, 1, 1};

  initial begin
    #(200_000 * 10);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    por = 1'b1; mode = 2'b01; pol = 1'b1; regsel = 1'b0;
    terms = '0; spare = 1'b1; oen = 1'b0; pad = 1'b0;
    #3;
    check("R8", "pin under clear", pin, 1'b0);
    check("R8", "fb under clear", fb, 1'b0);
    check("R6", "oe from pin", oe, 1'b1);
    repeat (2) @(posedge clk);
    #2;
    check("R8", "clear beats clock", fb, 1'b0);
    pol = 1'b0; #1;
    check("R8", "active-low pin under clear", pin, 1'b1);

    @(negedge clk);
    por = 1'b0; pol = 1'b1; #1;
    check("R6", "no change before edge", pin, 1'b0);
    @(posedge clk); #2;
    check("R6", "pin after capture", pin, 1'b1);
    check("R6", "fb after capture", fb, 1'b1);
    oen = 1'b1; #1;
    check("R6", "oe pin high disables", oe, 1'b0);
    pol = 1'b0; #1;
    check("R2", "polarity after register", pin, 1'b0);
    check("R2", "fb stays true", fb, 1'b1);

    @(negedge clk);
    spare = 1'b0; pol = 1'b1;
    @(posedge clk); #2;
    check("R6", "capture zero", fb, 1'b0);
    check("R6", "pin zero", pin, 1'b0);
    @(negedge clk);
    terms = 7'b0100000;
    @(posedge clk); #2;
    check("R6", "grouped term captured", fb, 1'b1);

    // R9: leave the registered configuration and come back
    @(negedge clk);
    mode = 2'b10; terms = '0; spare = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    mode = 2'b01; #1;
    check("R9", "fb held", fb, 1'b1);
    check("R9", "pin held", pin, 1'b1);
    @(posedge clk); #2;
    check("R6", "reload zero", fb, 1'b0);

    // R8: asynchronous clear mid-cycle
    @(negedge clk);
    spare = 1'b1;
    @(posedge clk); #2;
    check("R6", "reload one", fb, 1'b1);
    @(negedge clk); #1;
    por = 1'b1; #1;
    check("R8", "async clear", fb, 1'b0);
    @(negedge clk);
    por = 1'b0;

    // Table walk (R1 R2 R3 R4 R5 R7)
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {mode, pol, regsel, terms, spare, oen, pad} = VEC[i][16:3];
      #2;
      check($sformatf("R%0d", VREQ[i]), $sformatf("row %0d pin", i), pin, VEC[i][2]);
      check($sformatf("R%0d", VREQ[i]), $sformatf("row %0d oe", i), oe, VEC[i][1]);
      check($sformatf("R%0d", VREQ[i]), $sformatf("row %0d fb", i), fb, VEC[i][0]);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule